// File: doc/BRIEF.md
# Double-Data-Rate Write Output Path with Same-Edge Option

This block drives the write side of a source-synchronous memory interface. For each data pin it accepts two words from fabric logic: one meant for the high half of the clock and one meant for the low half. It then drives a pin that changes value on both clock edges, so each pin carries two data values per clock period. A second output cell, clocked from its own clock, forwards a strobe built from constant 1 and 0 inputs. The data clock runs a quarter period ahead of the strobe clock, which puts each strobe edge in the middle of the data window.

The data cell has two capture modes, chosen by a static mode input. In opposite-edge mode the low-half word is taken straight into a falling-edge register at the falling clock edge. In same-edge mode an extra rising-edge register sits in front of that falling-edge register. Fabric logic can then present both words at the same rising edge, and no path in the fabric has only half a clock period to settle.

Top module: `ddr_wr_path`

## Requirements
- R1: While `rst` is high at a clock edge, every internal register of both cells clears at that edge. `dq_out` and `strb_out` then read 0 in both halves of the clock, whatever the data inputs are.
- R2: The value of `d_rise` at a rising edge of `clk_dq` appears on `dq_out` for the whole high half of the clock that starts at that edge.
- R3: With `same_edge` = 0 (opposite-edge mode), the value of `d_fall` at a falling edge of `clk_dq` appears on `dq_out` for the low half that starts at that edge. The value of `d_fall` at the rising edge before it has no effect.
- R4: With `same_edge` = 1 (same-edge mode), the value of `d_fall` at a rising edge of `clk_dq` appears on `dq_out` for the low half that follows that edge. Changes to `d_fall` after that rising edge and before the falling edge have no effect.
- R5: `dq_out` can take a new value at every edge of `clk_dq`, so back-to-back cycles deliver two independent words per period.
- R6: After reset is released, `strb_out` is 1 during the high half of `clk_strb` and 0 during its low half.
- R7: Each of the WIDTH lanes of `dq_out` follows only its own bit of `d_rise` and `d_fall` (bit i of the output comes from bit i of the inputs).
- R8: `same_edge` is changed only while `rst` is high. When reset is released after a mode change, the newly selected mode applies from the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_dq | input | 1 | Data clock, a quarter period ahead of the strobe clock |
| clk_strb | input | 1 | Strobe clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| same_edge | input | 1 | 0 = opposite-edge capture, 1 = same-edge capture; static outside reset |
| d_rise | input | WIDTH | Word shown on the pins during the high half |
| d_fall | input | WIDTH | Word shown on the pins during the low half |
| dq_out | output | WIDTH | Double-rate data pins |
| strb_out | output | 1 | Forwarded strobe |

## Verification
The bench goes after the instant at which `d_fall` is sampled in each mode. In opposite-edge mode it places a wrong value on `d_fall` at the rising edge, and in same-edge mode it places a wrong value on `d_fall` between the rising and falling edges. A design that took the input at the wrong edge, or that bypassed the extra register, would then show the wrong word in the low half. Reset is asserted in the middle of traffic with all-ones inputs, so a register left out of the reset shows up as a nonzero half-period. Walking-one patterns would expose crossed or stuck lanes. Mode changes made during reset confirm that the new capture timing holds from the first cycle after release.

// File: rtl/ddr_out_pkg.sv
`timescale 1ns/1ps
package ddr_out_pkg;

  typedef enum logic {
    CAP_OPPOSITE = 1'b0,
    CAP_SAME     = 1'b1
  } cap_mode_e;

  // Selects which captured bit drives a pin in the current clock phase.
  function automatic logic half_pick(input logic hi_phase,
                                     input logic hi_bit,
                                     input logic lo_bit);
    return hi_phase ? hi_bit : lo_bit;
  endfunction

  // Source for the falling-edge register: the staged copy or the live input.
  function automatic logic fall_source(input cap_mode_e mode,
                                       input logic staged_bit,
                                       input logic live_bit);
    return (mode == CAP_SAME) ? staged_bit : live_bit;
  endfunction

endpackage

// File: rtl/ddr_edge_reg.sv
`timescale 1ns/1ps
module ddr_edge_reg #(
  parameter int W       = 8,
  parameter bit FALLING = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (FALLING) begin : g_neg
      always_ff @(negedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end else begin : g_pos
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/ddr_lane_mux.sv
`timescale 1ns/1ps
module ddr_lane_mux
  import ddr_out_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic [W-1:0] hi_word,
  input  logic [W-1:0] lo_word,
  output logic [W-1:0] pin
);

  generate
    for (genvar i = 0; i < W; i++) begin : g_lane
      always_comb pin[i] = half_pick(clk, hi_word[i], lo_word[i]);
    end
  endgenerate

endmodule

// File: rtl/ddr_out_cell.sv
`timescale 1ns/1ps
module ddr_out_cell
  import ddr_out_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  cap_mode_e    mode,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  output logic [W-1:0] pin,
  output logic [W-1:0] tap_hi_q,
  output logic [W-1:0] tap_lo_q,
  output logic [W-1:0] tap_stage_q
);

  logic [W-1:0] lo_src;

  // high-half word, rising edge
  ddr_edge_reg #(.W(W), .FALLING(1'b0)) u_hi (
    .clk(clk), .rst(rst), .d(hi_in), .q(tap_hi_q)
  );

  // same-edge staging register, rising edge
  ddr_edge_reg #(.W(W), .FALLING(1'b0)) u_stage (
    .clk(clk), .rst(rst), .d(lo_in), .q(tap_stage_q)
  );

  generate
    for (genvar i = 0; i < W; i++) begin : g_src
      always_comb lo_src[i] = fall_source(mode, tap_stage_q[i], lo_in[i]);
    end
  endgenerate

  // low-half word, falling edge
  ddr_edge_reg #(.W(W), .FALLING(1'b1)) u_lo (
    .clk(clk), .rst(rst), .d(lo_src), .q(tap_lo_q)
  );

  ddr_lane_mux #(.W(W)) u_mux (
    .clk(clk), .hi_word(tap_hi_q), .lo_word(tap_lo_q), .pin(pin)
  );

endmodule

// File: rtl/ddr_wr_path.sv
`timescale 1ns/1ps
module ddr_wr_path
  import ddr_out_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_dq,
  input  logic             clk_strb,
  input  logic             rst,
  input  logic             same_edge,
  input  logic [WIDTH-1:0] d_rise,
  input  logic [WIDTH-1:0] d_fall,
  output logic [WIDTH-1:0] dq_out,
  output logic             strb_out
);

  cap_mode_e        dq_mode;
  logic [WIDTH-1:0] dq_rise_q;
  logic [WIDTH-1:0] dq_fall_q;
  logic [WIDTH-1:0] dq_pre_q;
  logic             st_rise_q;
  logic             st_fall_q;
  logic             st_pre_q;

  assign dq_mode = same_edge ? CAP_SAME : CAP_OPPOSITE;

  ddr_out_cell #(.W(WIDTH)) u_data (
    .clk(clk_dq), .rst(rst), .mode(dq_mode),
    .hi_in(d_rise), .lo_in(d_fall), .pin(dq_out),
    .tap_hi_q(dq_rise_q), .tap_lo_q(dq_fall_q), .tap_stage_q(dq_pre_q)
  );

  // strobe: constant high word, constant low word
  ddr_out_cell #(.W(1)) u_strb (
    .clk(clk_strb), .rst(rst), .mode(CAP_OPPOSITE),
    .hi_in(1'b1), .lo_in(1'b0), .pin(strb_out),
    .tap_hi_q(st_rise_q), .tap_lo_q(st_fall_q), .tap_stage_q(st_pre_q)
  );

endmodule

// File: rtl/ddr_wr_path_chk.sv
`timescale 1ns/1ps
module ddr_wr_path_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_dq,
  input logic             clk_strb,
  input logic             rst,
  input logic             same_edge,
  input logic [WIDTH-1:0] d_rise,
  input logic [WIDTH-1:0] d_fall,
  input logic [WIDTH-1:0] dq_out,
  input logic             strb_out,
  input logic [WIDTH-1:0] dq_rise_q,
  input logic [WIDTH-1:0] dq_fall_q,
  input logic [WIDTH-1:0] dq_pre_q,
  input logic             st_rise_q,
  input logic             st_fall_q,
  input logic             st_pre_q
);

  logic [WIDTH-1:0] hold_rise, pre_hold, hold_fall;
  logic live_r, live_f, strb_live_r, strb_live_f;

  always_ff @(posedge clk_dq) begin
    hold_rise <= d_rise;
    pre_hold  <= d_fall;
    live_r    <= !rst;
  end

  always_ff @(negedge clk_dq) begin
    hold_fall <= same_edge ? pre_hold : d_fall;
    live_f    <= !rst && (!same_edge || live_r);
  end

  always_ff @(posedge clk_strb) strb_live_r <= !rst;
  always_ff @(negedge clk_strb) strb_live_f <= !rst;

  p_rise_load_r2: assert property (@(posedge clk_dq) disable iff (rst)
    1'b1 |=> dq_rise_q == $past(d_rise));

  p_high_half_r2: assert property (@(negedge clk_dq) disable iff (rst)
    live_r |-> dq_out == hold_rise);

  p_fall_load_r3: assert property (@(negedge clk_dq) disable iff (rst)
    !same_edge |=> dq_fall_q == $past(d_fall));

  p_low_half_r3: assert property (@(posedge clk_dq) disable iff (rst)
    (live_f && !same_edge) |-> dq_out == hold_fall);

  p_stage_load_r4: assert property (@(posedge clk_dq) disable iff (rst)
    same_edge |=> dq_pre_q == $past(d_fall));

  p_low_half_r4: assert property (@(posedge clk_dq) disable iff (rst)
    (live_f && same_edge) |-> dq_out == hold_fall);

  p_strb_high_r6: assert property (@(negedge clk_strb) disable iff (rst)
    strb_live_r |-> (strb_out && st_rise_q));

  p_strb_low_r6: assert property (@(posedge clk_strb) disable iff (rst)
    strb_live_f |-> (!strb_out && !st_fall_q && !st_pre_q));

  p_mode_static_r8: assert property (@(posedge clk_dq) disable iff (rst)
    live_r |-> $stable(same_edge));

endmodule

bind ddr_wr_path ddr_wr_path_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_dq(clk_dq), .clk_strb(clk_strb), .rst(rst), .same_edge(same_edge),
  .d_rise(d_rise), .d_fall(d_fall), .dq_out(dq_out), .strb_out(strb_out),
  .dq_rise_q(dq_rise_q), .dq_fall_q(dq_fall_q), .dq_pre_q(dq_pre_q),
  .st_rise_q(st_rise_q), .st_fall_q(st_fall_q), .st_pre_q(st_pre_q)
);

// File: tb/sim_ddr_wr_path.sv
`timescale 1ns/1ps
module sim_ddr_wr_path;
  localparam int W = 8;

  logic         clk_dq = 1'b0;
  logic         clk_strb = 1'b0;
  logic         rst = 1'b1;
  logic         same_edge = 1'b0;
  logic [W-1:0] d_rise = '0;
  logic [W-1:0] d_fall = '0;
  logic [W-1:0] dq_out;
  logic         strb_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  ddr_wr_path #(.WIDTH(W)) u0 (
    .clk_dq(clk_dq), .clk_strb(clk_strb), .rst(rst), .same_edge(same_edge),
    .d_rise(d_rise), .d_fall(d_fall), .dq_out(dq_out), .strb_out(strb_out)
  );

  always #5 clk_dq = ~clk_dq;
  initial begin
    #2.5;
    forever #5 clk_strb = ~clk_strb;
  end

  task automatic check(input string tag, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Reset with all-ones inputs; outputs stay 0 (R1). Mode set here (R8).
  task automatic do_reset(input logic mode);
    @(negedge clk_dq); #1;
    rst = 1'b1; same_edge = mode; d_rise = '1; d_fall = '1;
    repeat (2) @(posedge clk_dq);
    @(posedge clk_dq); #3;
    check("R1 dq high half in reset", dq_out, '0);
    check("R1 strobe in reset", {7'd0, strb_out}, '0);
    @(negedge clk_dq); #3;
    check("R1 dq low half in reset", dq_out, '0);
    check("R1 strobe low in reset", {7'd0, strb_out}, '0);
    rst = 1'b0;
  endtask

  // One clock period: 'a' in the high half, 'b' in the low half.
  // The decoy value on d_fall must not reach the pins (R3, R4).
  task automatic run_cycle(input string tag, input logic [W-1:0] a,
                           input logic [W-1:0] b);
    d_rise = a;
    d_fall = same_edge ? b : ~b;
    @(posedge clk_dq); #1;
    d_fall = same_edge ? ~b : b;
    #3;
    check({tag, " high half R2"}, dq_out, a);
    @(negedge clk_dq); #3;
    check({tag, same_edge ? " low half R4" : " low half R3"}, dq_out, b);
  endtask

  task automatic t_strobe;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_strb); #2;
      check("R6 strobe high half", {7'd0, strb_out}, 8'd1);
      @(negedge clk_strb); #2;
      check("R6 strobe low half", {7'd0, strb_out}, 8'd0);
    end
    @(negedge clk_dq); #1;
  endtask

  task automatic t_opposite;
    run_cycle("opp A5/3C", 8'hA5, 8'h3C);
    run_cycle("opp 00/FF", 8'h00, 8'hFF);
    run_cycle("opp FF/00", 8'hFF, 8'h00);
  endtask

  task automatic t_same;
    run_cycle("same 5A/C3 R8", 8'h5A, 8'hC3);
    run_cycle("same 0F/F0", 8'h0F, 8'hF0);
    run_cycle("same 81/7E", 8'h81, 8'h7E);
  endtask

  // Walking one on the high word and walking one from the other end on the low word (R7).
  task automatic t_lanes;
    for (int i = 0; i < W; i++)
      run_cycle("R7 lane", 8'h01 << i, 8'h80 >> i);
  endtask

  // Back-to-back words, a new value at every edge (R5).
  task automatic t_burst;
    for (int i = 0; i < 4; i++)
      run_cycle("R5 burst", 8'h10 + 8'(2 * i), 8'hE0 + 8'(2 * i + 1));
  endtask

  initial begin
    do_reset(1'b0);
    t_strobe();
    t_opposite();
    t_lanes();
    t_burst();
    do_reset(1'b1);
    t_same();
    t_lanes();
    t_burst();
    // mid-traffic reset and switch back to opposite-edge mode (R1, R8)
    do_reset(1'b0);
    run_cycle("R8 back to opposite", 8'h66, 8'h99);
    t_strobe();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule